// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width modulated outputs, each configured through a small memory-mapped register space. Every channel has a prescaler that slows the input clock by a power of two, a period counter, and a duty threshold. Each frame opens at the inactive level and switches to the active level once the counter reaches the duty value. A polarity bit swaps which output level is treated as active.

Software starts and stops channels through two write-only bit-mask registers. Each channel reports whether it is running, and a clear-on-read flag register records each completed frame. While a channel runs, its settings are frozen. The only way to change duty or period on the fly is a shared update register: the value written there is held and copied into duty or period at the next frame boundary. A stop request also waits for the current frame to end.

The register port is a plain single-cycle access with no back-pressure. A write is taken on the clock edge where `bus_we` is high. A read is requested with `bus_re`, and the data appears on `bus_rdata` one cycle later.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, no channel runs and every output is low.
- R2: A write of mask m to the start register (0x04) starts each stopped channel n whose bit n is 1. A write of mask m to the stop register (0x08) requests a stop for each channel whose bit n is 1. Zero bits leave their channels unchanged. Bit n of the run-state register (0x0C) is 1 while channel n runs.
- R3: Channel n's bank sits at 0x200 + n*0x20, with mode at +0x00, duty at +0x04, period at +0x08 and update at +0x10. Duty and period are CW bits wide. A frame lasts period*2^p clock cycles. The output is inactive for the first duty counts of the frame and active for the rest, so it is inactive in the first cycle after a start when duty > 0.
- R4: Mode bit 9 set makes the active level low and the inactive level high.
- R5: Mode bits 3:0 hold the prescaler p, and the channel counts once every 2^p clock cycles. A written value above 10 is stored, used and read back as 10.
- R6: When duty is greater than or equal to the effective period, the output stays inactive for the whole frame. A period of 0 acts as a period of 1.
- R7: A value written to the update register (+0x10) stays pending. At the next frame boundary it is copied into duty when mode bit 10 was 0 at write time, or into period when that bit was 1.
- R8: Writes to mode, duty or period are ignored while the channel runs.
- R9: A stop request takes effect at the end of the current frame. Until then the run-state bit stays 1. Afterwards the output holds the inactive level.
- R10: Bit n of the frame flag register (0x1C) is set at the end of each of channel n's frames. A read returns all flags and clears them, except a flag set in that same cycle.
- R11: Reads of the start and stop registers, of update registers and of unmapped offsets return zero.
- R12: `bus_rdata` carries the read data in the cycle after `bus_re` and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, one cycle after the read strobe |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A corrupted counter, prescaler or duty threshold changes the number of active cycles within a single frame. The bench catches this by counting active samples over whole frames. A pending update or stop request that is lost or applied early shows up as wrong read-back data or a wrong run-state bit. These are read within a few cycles of the boundary where the change should have occurred, or well before it. A frame flag that clears at the wrong moment is caught by the read-then-read-again check on the flag register.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int MAX_PSC = 10;

  localparam logic [11:0] OFF_START = 12'h004;
  localparam logic [11:0] OFF_STOP  = 12'h008;
  localparam logic [11:0] OFF_RUN   = 12'h00C;
  localparam logic [11:0] OFF_FLAG  = 12'h01C;

  localparam int BANK_BASE   = 32'h200;
  localparam int BANK_STRIDE = 32;

  localparam logic [4:0] SUB_MODE = 5'h00;
  localparam logic [4:0] SUB_DUTY = 5'h04;
  localparam logic [4:0] SUB_PER  = 5'h08;
  localparam logic [4:0] SUB_UPD  = 5'h10;

  typedef struct packed {
    logic       upd_sel;  // update target: 0 duty, 1 period
    logic       pol;      // inverted active level
    logic [3:0] psc;      // prescale exponent, already clamped
  } mode_t;

  function automatic logic [3:0] clamp_psc(input logic [3:0] p);
    return (p > 4'(MAX_PSC)) ? 4'(MAX_PSC) : p;
  endfunction

  function automatic logic [31:0] mode_word(input mode_t m);
    logic [31:0] w;
    w = '0;
    w[3:0] = m.psc;
    w[9]   = m.pol;
    w[10]  = m.upd_sel;
    return w;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int MAXP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] psc,
  output logic       tick
);
  timeunit 1ns; timeprecision 1ps;

  localparam int DVW = MAXP + 1;

  logic [DVW-1:0] div_q;
  logic [DVW-1:0] limit;

  assign limit = (DVW'(1) << psc) - DVW'(1);
  assign tick  = run && (div_q == limit);

  // free-running divider, held at zero while the channel is stopped
  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + DVW'(1);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          wr_mode,
  input  logic          wr_duty,
  input  logic          wr_per,
  input  logic          wr_upd,
  input  mode_t         mode_in,
  input  logic [CW-1:0] val_in,
  output logic          running,
  output logic          period_end,
  output logic          pwm,
  output mode_t         mode_q,
  output logic [CW-1:0] duty_q,
  output logic [CW-1:0] per_q
);
  timeunit 1ns; timeprecision 1ps;

  logic          tick;
  logic          stop_pend;
  logic          pend_vld;
  logic          pend_tgt;
  logic [CW-1:0] pend_val;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] eff_per;
  logic          active;
  logic          stop_now;

  pwm_prescaler #(.MAXP(MAX_PSC)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .psc   (mode_q.psc),
    .tick  (tick)
  );

  assign eff_per    = (per_q == '0) ? CW'(1) : per_q;
  assign period_end = tick && (cnt_q == eff_per - CW'(1));
  assign active     = running && (duty_q < eff_per) && (cnt_q >= duty_q);
  assign pwm        = active ^ mode_q.pol;
  assign stop_now   = (stop_pend && !start) || stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      cnt_q     <= '0;
      mode_q    <= '0;
      duty_q    <= '0;
      per_q     <= '0;
    end else if (!running) begin
      if (wr_mode) begin
        mode_q.upd_sel <= mode_in.upd_sel;
        mode_q.pol     <= mode_in.pol;
        mode_q.psc     <= clamp_psc(mode_in.psc);
      end
      if (wr_duty) duty_q <= val_in;
      if (wr_per)  per_q  <= val_in;
      if (start) begin
        running   <= 1'b1;
        cnt_q     <= '0;
        stop_pend <= 1'b0;
      end
    end else begin
      if (start)     stop_pend <= 1'b0;
      else if (stop) stop_pend <= 1'b1;
      if (period_end) begin
        cnt_q <= '0;
        if (pend_vld) begin
          if (pend_tgt) per_q  <= pend_val;
          else          duty_q <= pend_val;
        end
        if (stop_now) begin
          running   <= 1'b0;
          stop_pend <= 1'b0;
        end
      end else if (tick) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // pending update slot; a new write wins over the boundary clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_tgt <= 1'b0;
      pend_val <= '0;
    end else begin
      if (period_end) pend_vld <= 1'b0;
      if (wr_upd) begin
        pend_vld <= 1'b1;
        pend_tgt <= mode_q.upd_sel;
        pend_val <= val_in;
      end
    end
  end
endmodule

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_we,
  input  logic           bus_re,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW       = $clog2(BANK_STRIDE);
  localparam int BANK_END = BANK_BASE + NCH * BANK_STRIDE;

  logic                    in_bank;
  logic [CHW-1:0]          sel_ch;
  logic [SW-1:0]           sub;
  logic                    hit_start, hit_stop, hit_flag;
  logic [NCH-1:0]          ch_run, ch_end, ch_pol;
  logic [NCH-1:0][CW-1:0]  ch_duty, ch_per;
  mode_t                   ch_mode [NCH];
  mode_t                   mode_in;
  logic [NCH-1:0]          isr_q;
  logic [DW-1:0]           rd_word;
  logic                    unused_wbits;

  assign in_bank   = (32'(bus_addr) >= BANK_BASE) && (32'(bus_addr) < BANK_END);
  assign sel_ch    = bus_addr[SW +: CHW];
  assign sub       = bus_addr[SW-1:0];
  assign hit_start = bus_we && (bus_addr == AW'(OFF_START));
  assign hit_stop  = bus_we && (bus_addr == AW'(OFF_STOP));
  assign hit_flag  = bus_re && (bus_addr == AW'(OFF_FLAG));

  assign mode_in.upd_sel = bus_wdata[10];
  assign mode_in.pol     = bus_wdata[9];
  assign mode_in.psc     = bus_wdata[3:0];
  assign unused_wbits    = ^bus_wdata;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = bus_we && in_bank && (sel_ch == CHW'(n));

    pwm_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (hit_start && bus_wdata[n]),
      .stop       (hit_stop && bus_wdata[n]),
      .wr_mode    (hit && (sub == SUB_MODE)),
      .wr_duty    (hit && (sub == SUB_DUTY)),
      .wr_per     (hit && (sub == SUB_PER)),
      .wr_upd     (hit && (sub == SUB_UPD)),
      .mode_in    (mode_in),
      .val_in     (bus_wdata[CW-1:0]),
      .running    (ch_run[n]),
      .period_end (ch_end[n]),
      .pwm        (pwm_out[n]),
      .mode_q     (ch_mode[n]),
      .duty_q     (ch_duty[n]),
      .per_q      (ch_per[n])
    );

    assign ch_pol[n] = ch_mode[n].pol;
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == AW'(OFF_RUN)) begin
      rd_word = DW'(ch_run);
    end else if (bus_addr == AW'(OFF_FLAG)) begin
      rd_word = DW'(isr_q);
    end else if (in_bank) begin
      case (sub)
        SUB_MODE: rd_word = DW'(mode_word(ch_mode[sel_ch]));
        SUB_DUTY: rd_word = DW'(ch_duty[sel_ch]);
        SUB_PER:  rd_word = DW'(ch_per[sel_ch]);
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q     <= '0;
      bus_rdata <= '0;
    end else begin
      isr_q     <= (hit_flag ? '0 : isr_q) | ch_end;
      bus_rdata <= bus_re ? rd_word : '0;
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_re,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_rdata,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         ch_run,
  input logic [NCH-1:0]         ch_end,
  input logic [NCH-1:0]         ch_pol,
  input logic [NCH-1:0][CW-1:0] ch_duty,
  input logic [NCH-1:0]         isr_q
);
  timeunit 1ns; timeprecision 1ps;

  // R12: no read last cycle means zero read data
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));

  // R10: a flag read with no frame end in that cycle leaves all flags clear
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == AW'(OFF_FLAG)) && (ch_end == '0)) |=> (isr_q == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_a
    // R9: a stopped channel sits at its inactive level
    a_r9_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[n] |-> (pwm_out[n] == ch_pol[n]));

    // R9: a channel only stops at the end of a frame
    a_r9_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_run[n]) |-> $past(ch_end[n]));

    // R8: duty holds while running, except at a frame boundary
    a_r8_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[n] && $past(ch_run[n]) && !$past(ch_end[n])) |-> $stable(ch_duty[n]));
  end
endmodule

bind pwm_bank_ctrl pwm_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .ch_run    (ch_run),
  .ch_end    (ch_end),
  .ch_pol    (ch_pol),
  .ch_duty   (ch_duty),
  .isr_q     (isr_q)
);

// File: tb/tb_pwm_bank_ctrl.sv
module tb_pwm_bank_ctrl;
  timeunit 1ns; timeprecision 1ps;

  localparam int NCH = 4, CW = 16, AW = 12, DW = 32;

  // p, period, duty, pol, window cycles, expected active cycles
  localparam int NV = 7;
  localparam int VT [NV][6] = '{
    '{0, 10, 3, 0, 10, 7},
    '{1, 8, 2, 0, 16, 12},
    '{0, 5, 5, 0, 10, 0},
    '{2, 6, 0, 1, 24, 24},
    '{0, 0, 0, 0, 4, 4},
    '{15, 2, 1, 0, 2048, 1024},
    '{3, 4, 1, 1, 32, 24}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] pwm;

  pwm_bank_ctrl #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .pwm_out(pwm)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ca(input int ch, input int sub);
    return AW'(32'h200 + ch * 32 + sub);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic stop_ch(input int n);
    logic [DW-1:0] s;
    wr(12'h008, DW'(1) << n);
    s = DW'(1) << n;
    for (int k = 0; k < 3000 && s[n]; k++) rd(12'h00C, s);
    chk(!s[n], "R9 channel stops", longint'(s[n]), 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(pwm == '0, "R1 outputs low", longint'(pwm), 0);
    rd(12'h00C, d); chk(d == 0, "R1 run-state", d, 0);
    rd(12'h01C, d); chk(d == 0, "R1 flags", d, 0);
    rd(ca(0, 0), d); chk(d == 0, "R1 mode", d, 0);
    rd(ca(2, 8), d); chk(d == 0, "R1 period", d, 0);
    @(negedge clk); chk(rdata == 0, "R12 idle rdata", rdata, 0);

    // table walk on channel 0
    for (int v = 0; v < NV; v++) begin
      int p, per, dty, pol, win, expa, cnt, effp;
      string tag;
      p = VT[v][0]; per = VT[v][1]; dty = VT[v][2]; pol = VT[v][3];
      win = VT[v][4]; expa = VT[v][5];
      effp = (per == 0) ? 1 : per;
      tag = (dty >= effp || per == 0) ? "R6" : (pol != 0) ? "R4" : "R3";
      wr(ca(0, 0), DW'(p | (pol << 9)));
      wr(ca(0, 4), DW'(dty));
      wr(ca(0, 8), DW'(per));
      rd(ca(0, 0), d);
      chk(d == DW'(((p > 10) ? 10 : p) | (pol << 9)), "R5 mode readback", d,
          ((p > 10) ? 10 : p) | (pol << 9));
      wr(12'h004, 32'h1);
      if (dty > 0) chk(pwm[0] == pol[0], "R3 frame opens inactive", longint'(pwm[0]), pol);
      repeat (3) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (pwm[0] != pol[0]) cnt++;
      end
      chk(cnt == expa, tag, cnt, expa);
      stop_ch(0);
      chk(pwm[0] == pol[0], "R9 inactive after stop", longint'(pwm[0]), pol);
    end

    // R11 unreadable and unmapped offsets
    rd(12'h004, d); chk(d == 0, "R11 start reg", d, 0);
    rd(12'h010, d); chk(d == 0, "R11 unmapped global", d, 0);
    rd(ca(0, 16), d); chk(d == 0, "R11 update reg", d, 0);
    rd(12'h300, d); chk(d == 0, "R11 beyond banks", d, 0);

    // channel 1: frozen settings, duty update, deferred stop
    wr(ca(1, 0), 32'h0);
    wr(ca(1, 4), 32'd50);
    wr(ca(1, 8), 32'd200);
    wr(12'h004, 32'h2);
    wr(ca(1, 4), 32'd9);
    rd(ca(1, 4), d); chk(d == 50, "R8 duty write ignored", d, 50);
    wr(ca(1, 0), 32'h20F);
    rd(ca(1, 0), d); chk(d == 0, "R8 mode write ignored", d, 0);
    wr(ca(1, 16), 32'd120);
    rd(ca(1, 4), d); chk(d == 50, "R7 update still pending", d, 50);
    wr(12'h008, 32'h2);
    rd(12'h00C, d); chk(d == 2, "R9 still running after stop request", d, 2);
    repeat (220) @(negedge clk);
    rd(12'h00C, d); chk(d == 0, "R9 stopped at frame end", d, 0);
    chk(pwm[1] == 1'b0, "R9 output inactive", longint'(pwm[1]), 0);
    rd(ca(1, 4), d); chk(d == 120, "R7 duty updated at boundary", d, 120);

    // channel 2: period update via mode bit 10, start mask
    wr(ca(2, 0), 32'h400);
    wr(ca(2, 4), 32'd10);
    wr(ca(2, 8), 32'd100);
    wr(12'h004, 32'h4);
    rd(12'h00C, d); chk(d == 4, "R2 only masked channel starts", d, 4);
    wr(ca(2, 16), 32'd40);
    repeat (120) @(negedge clk);
    rd(ca(2, 8), d); chk(d == 40, "R7 period updated at boundary", d, 40);
    begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pwm[2]) cnt++;
      end
      chk(cnt == 30, "R7 new period in effect", cnt, 30);
    end
    stop_ch(2);

    // channel 3: frame flags clear on read
    rd(12'h01C, d);
    wr(ca(3, 0), 32'h0);
    wr(ca(3, 4), 32'd10);
    wr(ca(3, 8), 32'd50);
    wr(12'h004, 32'h8);
    rd(12'h01C, d); chk(d == 0, "R10 no flag before frame end", d, 0);
    repeat (60) @(negedge clk);
    rd(12'h01C, d); chk(d == 8, "R10 flag after frame end", d, 8);
    rd(12'h01C, d); chk(d == 0, "R10 flag cleared by read", d, 0);
    stop_ch(3);
    @(negedge clk); chk(rdata == 0, "R12 idle rdata", rdata, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule